// File: doc/BRIEF.md
# Memory Block Copy Engine

This engine moves a run of 16-bit words from one region of a single-port synchronous memory to another region of the same memory. It holds a source pointer, a destination pointer and a fixed end address. Each iteration reads the word at the source pointer, waits one clock for the memory to return it, and writes it to the destination pointer. After that store, the source pointer is compared against the end address. If it lies beyond the end, both pointers return to their starting values and the copy starts over. Otherwise both pointers advance by one word.

The end test runs after the store and before the pointers advance. So with the default addresses (source 0x0010, destination 0x0030, end 0x002F), one pass moves 33 words: source 0x0010 to 0x0030 go to 0x0030 to 0x0050. The last word read, at 0x0030, is the value this same pass wrote there first. The engine runs while its enable input is high and repeats passes without end. A one-cycle pulse marks each restart.

The memory port has no back-pressure. The memory must accept one request in every cycle, and it must return read data in the cycle after the read strobe. The engine holds no valid/ready handshake, so a slower memory would need a wrapper that gates the enable.

Top module: `blkcopy_engine`

## Requirements
- R1: A synchronous active-high reset puts the engine in idle. Busy, the read strobe, the write strobe and the pass pulse are all low. The pointers return to their starting values (source 0x0010, destination 0x0030).
- R2: While enable is low in idle, no strobe is asserted and busy stays low. In the cycle after enable is sampled high at a clock edge, the read strobe is high with address 0x0010.
- R3: Each iteration reads at the source pointer. It then writes, at the destination pointer, the exact word the memory returned for that read.
- R4: The read and write strobes are never high in the same cycle. Each write strobe comes exactly two cycles after its read strobe.
- R5: After a store, if the source pointer is unsigned-greater than the end address 0x002F, the next read is at 0x0010 and the next write is at 0x0030. Otherwise both pointers rise by one. A pass is therefore 33 words.
- R6: After exactly one full pass, destination word 0x0050 holds the original value of 0x0010, and 0x004F holds the original value of 0x002F.
- R7: The pass pulse is high for exactly one cycle, in the cycle after the store that causes a restart. It is low at all other times.
- R8: If enable falls during a word, the engine still completes that word's store. Busy is low in the cycle after the store, and no further strobe follows.
- R9: Busy is high in every cycle in which a read or write strobe is high.
- R10: Stopping through enable does not reset the pointers. When enable rises again, copying resumes with the next word of the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request; copying proceeds while high |
| mem_addr | output | 16 | Memory address (source on reads, destination on writes) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after the read strobe |
| busy | output | 1 | High whenever the engine is not idle |
| pass_done | output | 1 | One-cycle pulse after the store that restarts the copy |

## Verification
A wrong pointer value shows as a wrong address on the very next read or write strobe. A skipped or extra sequencing state shows at once in the spacing between the read and the write. A wrong end compare shows as a wrong restart address or a misplaced pass pulse. That fault appears within one word (three cycles) of the 33rd store of a pass. A capture fault in the data path appears as wrong write data on the same word, and it then persists into the memory contents, which the bench compares region by region at the end of each run.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
  typedef enum logic [1:0] {
    CP_IDLE  = 2'd0,
    CP_READ  = 2'd1,
    CP_HOLD  = 2'd2,
    CP_WRITE = 2'd3
  } cp_state_t;
endpackage

// File: rtl/blkcopy_ptrs.sv
module blkcopy_ptrs #(
  parameter int unsigned AW       = 16,
  parameter int unsigned SRC_INIT = 'h0010,
  parameter int unsigned DST_INIT = 'h0030,
  parameter int unsigned END_ADDR = 'h002F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          wrap
);
  localparam logic [AW-1:0] SRC0 = AW'(SRC_INIT);
  localparam logic [AW-1:0] DST0 = AW'(DST_INIT);
  localparam logic [AW-1:0] LAST = AW'(END_ADDR);
  localparam logic [AW-1:0] OFFS = DST0 - SRC0;
  localparam logic [AW-1:0] ONE  = AW'(1);

  // unsigned strict compare taken before the increment
  assign wrap = (src > LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      src <= SRC0;
      dst <= DST0;
    end else if (step) begin
      if (wrap) begin
        src <= SRC0;
        dst <= DST0;
      end else begin
        src <= src + ONE;
        dst <= dst + ONE;
      end
    end
  end

  AST_DST_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (dst - src) == OFFS); // R5
  AST_SRC_BOUND: assert property (@(posedge clk) disable iff (rst)
    src <= LAST + ONE); // R5
endmodule

// File: rtl/blkcopy_dreg.sv
module blkcopy_dreg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/blkcopy_ctrl.sv
module blkcopy_ctrl
  import blkcopy_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic wrap,
  output logic rd_en,
  output logic cap_en,
  output logic wr_en,
  output logic busy,
  output logic pass_done
);
  cp_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      CP_IDLE:  if (enable) state_nx = CP_READ;
      CP_READ:  state_nx = CP_HOLD;
      CP_HOLD:  state_nx = CP_WRITE;
      CP_WRITE: state_nx = enable ? CP_READ : CP_IDLE;
      default:  state_nx = CP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CP_IDLE;
      pass_done <= 1'b0;
    end else begin
      state     <= state_nx;
      pass_done <= (state == CP_WRITE) && wrap;
    end
  end

  assign rd_en  = (state == CP_READ);
  assign cap_en = (state == CP_HOLD);
  assign wr_en  = (state == CP_WRITE);
  assign busy   = (state != CP_IDLE);

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rd_en, 2)); // R4
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(enable)); // R2
  AST_PASS_ONE: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> !pass_done); // R7
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !enable) |=> !busy); // R8
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine #(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 16,
  parameter int unsigned SRC_INIT = 'h0010,
  parameter int unsigned DST_INIT = 'h0030,
  parameter int unsigned END_ADDR = 'h002F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          pass_done
);
  logic [AW-1:0] src, dst;
  logic          wrap, rd_en, cap_en, wr_en;

  blkcopy_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .wrap      (wrap),
    .rd_en     (rd_en),
    .cap_en    (cap_en),
    .wr_en     (wr_en),
    .busy      (busy),
    .pass_done (pass_done)
  );

  blkcopy_ptrs #(
    .AW       (AW),
    .SRC_INIT (SRC_INIT),
    .DST_INIT (DST_INIT),
    .END_ADDR (END_ADDR)
  ) u_ptrs (
    .clk  (clk),
    .rst  (rst),
    .step (wr_en),
    .src  (src),
    .dst  (dst),
    .wrap (wrap)
  );

  blkcopy_dreg #(.DW(DW)) u_dreg (
    .clk (clk),
    .rst (rst),
    .cap (cap_en),
    .d   (mem_rdata),
    .q   (mem_wdata)
  );

  assign mem_rd   = rd_en;
  assign mem_wr   = wr_en;
  assign mem_addr = wr_en ? dst : src;

  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> busy); // R9
endmodule

// File: tb/sim_blkcopy_engine.sv
`timescale 1ns/1ps
module sim_blkcopy_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rd, mem_wr, busy, pass_done;

  always #4 clk = ~clk;  // 125 MHz

  blkcopy_engine u0 (
    .clk(clk), .rst(rst), .enable(enable), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .pass_done(pass_done)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int pulses = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i, input logic [15:0] seed);
    return 16'(i * 16'h9E37) ^ seed ^ 16'(i << 8);
  endfunction

  // memory model, one-cycle read latency
  logic [15:0] mem    [0:255];
  logic [15:0] refmem [0:255];
  logic        fill_go = 1'b0;
  logic [15:0] fill_seed = '0;

  always @(posedge clk) begin
    if (fill_go)
      for (int i = 0; i < 256; i++) mem[i] <= pat(i, fill_seed);
    else if (mem_wr)
      mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  // transaction monitor with its own reference pointers
  logic [15:0] m_src, m_dst, held;
  int          rd_age;
  bit          exp_pulse;

  always @(negedge clk) begin
    cycles++;
    if (pass_done) pulses++;
    if (fill_go)
      for (int i = 0; i < 256; i++) refmem[i] = pat(i, fill_seed);
    if (rst) begin
      m_src = 16'h0010; m_dst = 16'h0030; rd_age = 99; exp_pulse = 0;
    end else begin
      if (pass_done || exp_pulse) chk(pass_done == exp_pulse, "R7 pass pulse", 32'(pass_done), 32'(exp_pulse));
      exp_pulse = 0;
      if (mem_rd && mem_wr) chk(0, "R4 strobes overlap", 1, 0);
      if (mem_rd || mem_wr) chk(busy == 1'b1, "R9 busy with strobe", 32'(busy), 1);
      if (mem_rd) begin
        chk(mem_addr == m_src, "R3 read address", 32'(mem_addr), 32'(m_src));
        held = refmem[m_src[7:0]];
        rd_age = 0;
      end
      if (mem_wr) begin
        chk(rd_age == 2, "R4 write spacing", 32'(rd_age), 2);
        chk(mem_addr == m_dst, "R3 write address", 32'(mem_addr), 32'(m_dst));
        chk(mem_wdata == held, "R3 write data", 32'(mem_wdata), 32'(held));
        refmem[m_dst[7:0]] = held;
        if (m_src > 16'h002F) begin  // R5 restart
          m_src = 16'h0010; m_dst = 16'h0030; exp_pulse = 1;
        end else begin
          m_src++; m_dst++;
        end
      end
      if (rd_age < 99) rd_age++;
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 150000) begin
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; enable = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_fill(input logic [15:0] seed);
    @(negedge clk); fill_seed = seed; fill_go = 1'b1;
    @(negedge clk); fill_go = 1'b0;
  endtask

  // {seed, words to copy}
  localparam logic [23:0] VECS [0:5] = '{
    {16'h1234, 8'd1}, {16'hA5C3, 8'd5}, {16'h0F0F, 8'd32},
    {16'h7E11, 8'd33}, {16'hBEEF, 8'd34}, {16'h5A5A, 8'd70}
  };

  initial begin
    for (int v = 0; v < 6; v++) begin
      logic [15:0] seed;
      int nw, n, p0, bad;
      seed = VECS[v][23:8];
      nw   = int'(VECS[v][7:0]);
      do_reset();
      do_fill(seed);
      chk(!busy && !mem_rd && !mem_wr && !pass_done, "R1 reset state",
          {28'd0, busy, mem_rd, mem_wr, pass_done}, 0);
      p0 = pulses;
      n = 0;
      enable = 1'b1;
      while (n < nw) begin
        @(negedge clk);
        if (mem_wr) n++;
      end
      enable = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy && !mem_rd && !mem_wr, "R8 idle after stop",
          {29'd0, busy, mem_rd, mem_wr}, 0);
      chk((pulses - p0) == nw / 33, "R7 pass count", 32'(pulses - p0), 32'(nw / 33));
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== refmem[i]) bad++;
      chk(bad == 0, "R3 memory image", 32'(bad), 0);
      if (nw >= 33 && nw < 66) begin
        chk(mem[8'h50] == pat('h10, seed), "R6 word 0x50", 32'(mem[8'h50]), 32'(pat('h10, seed)));
        chk(mem[8'h4F] == pat('h2F, seed), "R6 word 0x4F", 32'(mem[8'h4F]), 32'(pat('h2F, seed)));
      end
    end

    // R2: idle while enable low
    begin
      int strobes;
      do_reset();
      do_fill(16'h3C3C);
      strobes = 0;
      repeat (20) begin
        @(negedge clk);
        if (mem_rd || mem_wr || busy) strobes++;
      end
      chk(strobes == 0, "R2 quiet while disabled", 32'(strobes), 0);
    end

    // R2 start, R8 stop mid-word, R10 resume
    begin
      int wrs;
      enable = 1'b1;
      @(negedge clk);
      chk(mem_rd && mem_addr == 16'h0010, "R2 first read", {mem_rd, 15'd0, mem_addr}, {1'b1, 15'd0, 16'h0010});
      enable = 1'b0;
      @(negedge clk);
      chk(busy == 1'b1, "R9 busy during hold", 32'(busy), 1);
      @(negedge clk);
      chk(mem_wr && mem_addr == 16'h0030, "R8 store completes", {mem_wr, 15'd0, mem_addr}, {1'b1, 15'd0, 16'h0030});
      @(negedge clk);
      chk(busy == 1'b0, "R8 busy low after store", 32'(busy), 0);
      wrs = 0;
      repeat (6) begin
        @(negedge clk);
        if (mem_rd || mem_wr) wrs++;
      end
      chk(wrs == 0, "R8 no further strobes", 32'(wrs), 0);
      chk(mem[8'h30] == pat('h10, 16'h3C3C), "R8 word copied", 32'(mem[8'h30]), 32'(pat('h10, 16'h3C3C)));
      enable = 1'b1;
      @(negedge clk);
      chk(mem_rd && mem_addr == 16'h0011, "R10 resume address", {mem_rd, 15'd0, mem_addr}, {1'b1, 15'd0, 16'h0011});
      enable = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R1: reset after activity returns the pointers to their start
    do_reset();
    chk(!busy && !pass_done, "R1 reset clears busy", {30'd0, busy, pass_done}, 0);
    enable = 1'b1;
    @(negedge clk);
    chk(mem_rd && mem_addr == 16'h0010, "R1 pointers reloaded", {mem_rd, 15'd0, mem_addr}, {1'b1, 15'd0, 16'h0010});
    enable = 1'b0;
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule